// File: doc/BRIEF.md
# Receive Packet Buffer with Flow-Control Requests and Cut-Through Forwarding

This block sits between one port's receive MAC and the system-side packet interface. Words arrive from the MAC with start and end markers and cannot be stalled. They are stored in a circular buffer and are later read out by the system side with a valid/ready handshake. Each output word carries start, end and error sideband bits.

The block counts every stored word that has not yet been read, including words of a packet that is still arriving. When this count reaches a programmable high mark, it raises a one-cycle request for a pause frame. When the count later drops under a programmable low mark, it raises a one-cycle request for a resume frame. The frames themselves are built elsewhere.

A programmable transfer length sets how each packet is forwarded. A packet no longer than this length is held back until its last word arrives. If the MAC flags such a packet as bad, the write pointer moves back to the packet's first word and the packet disappears. A packet that grows past the length is released word by word before its end arrives, and from then on it can no longer be discarded. If the buffer fills in the middle of a packet, that packet is cut short and its last stored word is marked as errored.

Top module: `rx_cut_fifo`

## Requirements
- R1: After reset, `sys_valid`, `pause_req` and `resume_req` are all 0.
- R2: A packet of at most `cfg_cut_len` words gives no output before its end word is written. It becomes readable in the cycle that follows the clock edge which writes its end word.
- R3: A packet of at most `cfg_cut_len` words whose end word has `mac_drop`=1 is removed completely: none of its words are ever presented, and the next packet comes out intact.
- R4: When word number `cfg_cut_len`+1 of a packet is written, that word and all earlier words of the packet become readable at once, before the end word arrives. Each later word becomes readable right after it is written.
- R5: For a packet longer than `cfg_cut_len` words, `mac_drop` on its end word is ignored. Every word is delivered with `sys_err`=0.
- R6: Fill is the number of written words not yet read, counting words of a packet still being received. `pause_req` pulses for exactly one cycle when fill reaches `cfg_hi_mark`.
- R7: After a pause request, `resume_req` pulses for exactly one cycle when fill falls below `cfg_lo_mark`.
- R8: No second pause request is made while fill stays at or above the low mark, and no resume request is made without a pause request before it. The two requests are never high together.
- R9: A MAC word that arrives while all 2^`ADDR_W` entries are filled is discarded. The last stored word of its packet gets end=1 and error=1, and that packet is released. The packet's remaining words up to its end are discarded. A packet whose first word meets a full buffer is lost entirely.
- R10: Words leave in arrival order, with `sys_sop`=1 on a packet's first word and `sys_eop`=1 on its last. While `sys_ready`=0, the presented word and its sideband bits hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hi_mark | input | ADDR_W+1 | Fill level that triggers a pause request |
| cfg_lo_mark | input | ADDR_W+1 | Fill level under which a resume request follows a pause |
| cfg_cut_len | input | ADDR_W+1 | Longest packet, in words, that is held back and droppable |
| mac_valid | input | 1 | MAC word present |
| mac_data | input | DATA_W | MAC word |
| mac_sop | input | 1 | First word of a packet |
| mac_eop | input | 1 | Last word of a packet |
| mac_drop | input | 1 | With the end word: discard the packet if still droppable |
| sys_valid | output | 1 | Output word available |
| sys_ready | input | 1 | System side takes the word |
| sys_data | output | DATA_W | Output word |
| sys_sop | output | 1 | Output word is a packet's first |
| sys_eop | output | 1 | Output word is a packet's last |
| sys_err | output | 1 | Output packet was truncated |
| pause_req | output | 1 | One-cycle request to send a pause frame |
| resume_req | output | 1 | One-cycle request to send a resume frame |

## Verification
Fill, the commit point and the output head all come from registers that change on the edge that accepts a MAC word or a pop. `sys_valid`, `pause_req` and `resume_req` are combinational from those registers, so each result is due in the cycle right after that edge, with no further delay. The bench changes inputs at the falling edge and steps over exactly one rising edge. It then samples at the next falling edge, so every check looks at the state left by that one edge. It follows fill word by word during sends and pop by pop during drains, and it expects a request at exactly one sample.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

  typedef struct packed {
    logic sop;
    logic eop;
    logic err;
  } rcf_tag_t;

  // words written but not read, modulo the pointer range
  function automatic int unsigned fill_of(int unsigned wr, int unsigned rd,
                                          int unsigned ptr_w);
    return (wr - rd) & ((32'd1 << ptr_w) - 32'd1);
  endfunction

  // length counter that stops at its top value
  function automatic int unsigned sat_inc(int unsigned v, int unsigned w);
    int unsigned top;
    top = (32'd1 << w) - 32'd1;
    return (v >= top) ? top : v + 32'd1;
  endfunction

  // a packet is past the transfer length once its word count exceeds it
  function automatic logic past_cut(int unsigned words, int unsigned cut);
    return words > cut;
  endfunction

endpackage

// File: rtl/rcf_mem.sv
module rcf_mem
  import rcf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  rcf_tag_t          wr_tag,
  input  logic              fix_en,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output rcf_tag_t          rd_tag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  rcf_tag_t          tag_q  [DEPTH];

  // one write per cycle: a new word, or closing the last stored word
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_q[wr_addr] <= wr_data;
      tag_q[wr_addr]  <= wr_tag;
    end else if (fix_en) begin
      tag_q[fix_addr].eop <= 1'b1;
      tag_q[fix_addr].err <= 1'b1;
    end
  end

  assign rd_data = data_q[rd_addr];
  assign rd_tag  = tag_q[rd_addr];
endmodule

// File: rtl/rcf_wr_ctl.sv
module rcf_wr_ctl
  import rcf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_drop,
  input  logic              full,
  input  logic [CNT_W-1:0]  cut_len,
  output logic [CNT_W-1:0]  wr_ptr,
  output logic [CNT_W-1:0]  cmt_ptr,
  output logic              mem_we,
  output logic              mem_fix,
  output logic [ADDR_W-1:0] fix_addr,
  output logic              evt_drop,
  output logic              evt_trunc,
  output logic              pkt_cut
);
  logic [CNT_W-1:0] wr_q, wr_d, cmt_q, cmt_d, base_q, base_d;
  logic [CNT_W-1:0] len_q, len_d, st_base, st_len, new_len;
  logic             cut_q, cut_d, disc_q, disc_d, st_cut, now_cut;

  assign st_base = in_sop ? wr_q : base_q;
  assign st_len  = in_sop ? '0 : len_q;
  assign st_cut  = in_sop ? 1'b0 : cut_q;
  assign new_len = CNT_W'(sat_inc(32'(st_len), CNT_W));
  assign now_cut = st_cut | past_cut(32'(new_len), 32'(cut_len));

  always_comb begin
    wr_d      = wr_q;
    cmt_d     = cmt_q;
    base_d    = base_q;
    len_d     = len_q;
    cut_d     = cut_q;
    disc_d    = disc_q;
    mem_we    = 1'b0;
    mem_fix   = 1'b0;
    evt_drop  = 1'b0;
    evt_trunc = 1'b0;
    if (in_valid) begin
      if (disc_q && !in_sop) begin
        if (in_eop) disc_d = 1'b0;
      end else if (full) begin
        evt_trunc = 1'b1;
        disc_d    = !in_eop;
        if (!in_sop) begin
          mem_fix = 1'b1;
          cmt_d   = wr_q;
        end
      end else begin
        mem_we = 1'b1;
        wr_d   = wr_q + CNT_W'(1);
        base_d = st_base;
        len_d  = new_len;
        cut_d  = now_cut;
        disc_d = 1'b0;
        if (in_eop) begin
          if (!now_cut && in_drop) begin
            wr_d     = st_base;
            evt_drop = 1'b1;
          end else begin
            cmt_d = wr_q + CNT_W'(1);
          end
        end else if (now_cut) begin
          cmt_d = wr_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      cmt_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      cut_q  <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      cmt_q  <= cmt_d;
      base_q <= base_d;
      len_q  <= len_d;
      cut_q  <= cut_d;
      disc_q <= disc_d;
    end
  end

  assign wr_ptr   = wr_q;
  assign cmt_ptr  = cmt_q;
  assign fix_addr = wr_q[ADDR_W-1:0] - ADDR_W'(1);
  assign pkt_cut  = cut_q;
endmodule

// File: rtl/rcf_pause.sv
module rcf_pause #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] hi_mark,
  input  logic [CNT_W-1:0] lo_mark,
  output logic             pause_req,
  output logic             resume_req
);
  logic paused_q;

  assign pause_req  = !paused_q && (fill >= hi_mark);
  assign resume_req = paused_q && (fill < lo_mark);

  always_ff @(posedge clk) begin
    if (!rst_n)          paused_q <= 1'b0;
    else if (pause_req)  paused_q <= 1'b1;
    else if (resume_req) paused_q <= 1'b0;
  end
endmodule

// File: rtl/rx_cut_fifo.sv
module rx_cut_fifo
  import rcf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   cfg_hi_mark,
  input  logic [ADDR_W:0]   cfg_lo_mark,
  input  logic [ADDR_W:0]   cfg_cut_len,
  input  logic              mac_valid,
  input  logic [DATA_W-1:0] mac_data,
  input  logic              mac_sop,
  input  logic              mac_eop,
  input  logic              mac_drop,
  output logic              sys_valid,
  input  logic              sys_ready,
  output logic [DATA_W-1:0] sys_data,
  output logic              sys_sop,
  output logic              sys_eop,
  output logic              sys_err,
  output logic              pause_req,
  output logic              resume_req
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [CNT_W-1:0]  wr_ptr, cmt_ptr, rd_q, fill;
  logic              full, pop, mem_we, mem_fix, evt_drop, evt_trunc, pkt_cut;
  logic [ADDR_W-1:0] fix_addr;
  rcf_tag_t          wr_tag, rd_tag;

  assign fill      = CNT_W'(fill_of(32'(wr_ptr), 32'(rd_q), CNT_W));
  assign full      = (fill == CNT_W'(DEPTH));
  assign sys_valid = (rd_q != cmt_ptr);
  assign pop       = sys_valid && sys_ready;
  assign wr_tag    = '{sop: mac_sop, eop: mac_eop, err: 1'b0};

  rcf_wr_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) wr_ctl_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(mac_valid), .in_sop(mac_sop), .in_eop(mac_eop), .in_drop(mac_drop),
    .full(full), .cut_len(cfg_cut_len),
    .wr_ptr(wr_ptr), .cmt_ptr(cmt_ptr),
    .mem_we(mem_we), .mem_fix(mem_fix), .fix_addr(fix_addr),
    .evt_drop(evt_drop), .evt_trunc(evt_trunc), .pkt_cut(pkt_cut)
  );

  rcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk),
    .wr_en(mem_we), .wr_addr(wr_ptr[ADDR_W-1:0]), .wr_data(mac_data), .wr_tag(wr_tag),
    .fix_en(mem_fix), .fix_addr(fix_addr),
    .rd_addr(rd_q[ADDR_W-1:0]), .rd_data(sys_data), .rd_tag(rd_tag)
  );

  rcf_pause #(.CNT_W(CNT_W)) pause_i (
    .clk(clk), .rst_n(rst_n), .fill(fill),
    .hi_mark(cfg_hi_mark), .lo_mark(cfg_lo_mark),
    .pause_req(pause_req), .resume_req(resume_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   rd_q <= '0;
    else if (pop) rd_q <= rd_q + CNT_W'(1);
  end

  assign sys_sop = rd_tag.sop;
  assign sys_eop = rd_tag.eop;
  assign sys_err = rd_tag.err;
endmodule

// File: rtl/rx_cut_fifo_chk.sv
module rx_cut_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pause_req,
  input logic              resume_req,
  input logic              sys_valid,
  input logic              sys_ready,
  input logic [DATA_W-1:0] sys_data,
  input logic              sys_sop,
  input logic              sys_eop,
  input logic              sys_err,
  input logic [ADDR_W:0]   fill,
  input logic              mac_valid,
  input logic              mac_sop,
  input logic              pkt_cut,
  input logic              evt_drop
);
  localparam int DEPTH = 1 << ADDR_W;

  AST_PAUSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> !pause_req); // R6
  AST_RESUME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |=> !resume_req); // R7
  AST_FLOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_req && resume_req)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) <= DEPTH); // R9
  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && !sys_ready) |=> (sys_valid && $stable(sys_data) && $stable(sys_sop)
                                    && $stable(sys_eop) && $stable(sys_err))); // R10
  AST_CUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cut && mac_valid && !mac_sop) |-> !evt_drop); // R5
  AST_VALID_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    sys_valid |-> (fill != '0)); // R2
endmodule

bind rx_cut_fifo rx_cut_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pause_req(pause_req), .resume_req(resume_req),
  .sys_valid(sys_valid), .sys_ready(sys_ready), .sys_data(sys_data),
  .sys_sop(sys_sop), .sys_eop(sys_eop), .sys_err(sys_err), .fill(fill),
  .mac_valid(mac_valid), .mac_sop(mac_sop), .pkt_cut(pkt_cut), .evt_drop(evt_drop)
);

// File: tb/rx_cut_fifo_tb_top.sv
module rx_cut_fifo_tb_top;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVEC   = 7;
  // each row: packet length, transfer length, drop flag on end word
  localparam int VEC [NVEC][3] = '{
    '{4, 8, 0}, '{4, 8, 1}, '{8, 8, 1}, '{9, 8, 1},
    '{6, 2, 0}, '{1, 0, 1}, '{1, 4, 1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W:0]   cfg_hi_mark = '1, cfg_lo_mark = '0, cfg_cut_len = '0;
  logic              mac_valid = 1'b0, mac_sop = 1'b0, mac_eop = 1'b0, mac_drop = 1'b0;
  logic [DATA_W-1:0] mac_data = '0;
  logic              sys_ready = 1'b0;
  logic              sys_valid, sys_sop, sys_eop, sys_err, pause_req, resume_req;
  logic [DATA_W-1:0] sys_data;
  int                total = 0, bad = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  rx_cut_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_hi_mark(cfg_hi_mark), .cfg_lo_mark(cfg_lo_mark), .cfg_cut_len(cfg_cut_len),
    .mac_valid(mac_valid), .mac_data(mac_data), .mac_sop(mac_sop),
    .mac_eop(mac_eop), .mac_drop(mac_drop),
    .sys_valid(sys_valid), .sys_ready(sys_ready), .sys_data(sys_data),
    .sys_sop(sys_sop), .sys_eop(sys_eop), .sys_err(sys_err),
    .pause_req(pause_req), .resume_req(resume_req)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write
  task automatic send(int data, bit sop, bit eop, bit drop);
    mac_valid = 1'b1;
    mac_data  = DATA_W'(data);
    mac_sop   = sop;
    mac_eop   = eop;
    mac_drop  = drop;
    @(posedge clk);
    @(negedge clk);
    mac_valid = 1'b0;
    mac_drop  = 1'b0;
  endtask

  task automatic drain(string req, int base, int n, bit err_last);
    sys_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk({req, " valid"}, int'(sys_valid), 1);
      chk({req, " data"}, int'(sys_data), base + i);
      chk({req, " sop"}, int'(sys_sop), int'(i == 0));
      chk({req, " eop"}, int'(sys_eop), int'(i == n - 1));
      chk({req, " err"}, int'(sys_err), int'(err_last && i == n - 1));
      @(posedge clk);
      @(negedge clk);
    end
    sys_ready = 1'b0;
    chk({req, " empty after drain"}, int'(sys_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(sys_valid), 0);
    chk("R1 pause", int'(pause_req), 0);
    chk("R1 resume", int'(resume_req), 0);

    // vector table: R2 R3 R4 R5 R10
    for (int e = 0; e < NVEC; e++) begin
      int  len, cut, base, nout;
      bit  drop, keep;
      len  = VEC[e][0];
      cut  = VEC[e][1];
      drop = VEC[e][2] != 0;
      base = 32 * e;
      keep = !(drop && len <= cut);
      nout = keep ? len : 0;
      cfg_cut_len = (ADDR_W + 1)'(cut);
      for (int k = 1; k <= len; k++) begin
        send(base + k - 1, k == 1, k == len, drop && k == len);
        if (k > cut) chk("R4 early release", int'(sys_valid), 1);
        else if (k == len) chk(keep ? "R2 release at end" : "R3 dropped",
                               int'(sys_valid), int'(keep));
        else chk("R2 held back", int'(sys_valid), 0);
      end
      repeat (2) @(negedge clk);
      if (len > cut && drop) chk("R5 drop ignored", int'(sys_valid), 1);
      drain("R10 table", base, nout, 1'b0);
    end

    // pause and resume with hysteresis: R6 R7 R8
    cfg_cut_len = '1;
    cfg_hi_mark = 10;
    cfg_lo_mark = 4;
    for (int k = 1; k <= 12; k++) begin
      send(300 + k, k == 1, k == 12, 1'b0);
      chk("R6 pause pulse", int'(pause_req), int'(k == 10));
      chk("R8 no early resume", int'(resume_req), 0);
    end
    sys_ready = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7 resume pulse", int'(resume_req), int'(n == 9));
      chk("R8 no repeat pause", int'(pause_req), 0);
    end
    sys_ready = 1'b0;
    chk("R7 drained", int'(sys_valid), 0);

    // overflow truncation: R9
    cfg_hi_mark = '1;
    cfg_lo_mark = '0;
    for (int k = 1; k <= 20; k++) begin
      send(100 + k - 1, k == 1, k == 20, 1'b0);
      if (k == 16) chk("R9 held while filling", int'(sys_valid), 0);
      if (k == 17) chk("R9 released on overflow", int'(sys_valid), 1);
    end
    send(500, 1'b1, 1'b0, 1'b0);
    send(501, 1'b0, 1'b1, 1'b0);
    drain("R9 truncated", 100, DEPTH, 1'b1);
    for (int k = 1; k <= 3; k++) send(200 + k - 1, k == 1, k == 3, 1'b0);
    drain("R9 recovery", 200, 3, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule